// File: doc/BRIEF.md
# DSP Pointer Register File

This block is the storage side of a DSP address generator. It keeps a bank of address pointers, a bank of step offsets and a bank of modifier words, one of each per pointer index. A shared host data bus can load or inspect any of them. The update arithmetic names one pointer index and receives that pointer together with the offset and the modifier of the same index. It returns the updated pointer through a primary write-back port. A secondary adder path serves two fixed pointers, used by dual reads and by pointer-plus-immediate updates. It has its own read port and its own write-back port.

A value moved over the bus cannot be used as a pointer by the next instruction; it becomes usable by the instruction after that. The block tracks this per register and flags a hazard whenever the arithmetic asks for a register that is still settling. One clock cycle counts as one instruction step.

Top module: `dsp_ptr_file`

## Requirements
- R1: In the first cycle after a synchronous reset every pointer and every offset reads 0, every modifier reads 16'hFFFF, and no hazard is flagged.
- R2: A bus write commits at the next clock edge to the register chosen by class and index (class 0 = pointer, 1 = offset, 2 = modifier). The bus read port returns the chosen register in the same cycle. Class 3 reads as 0, and a class 3 write changes no register.
- R3: The primary read port returns pointer k, offset k and modifier k in the same cycle that index k is presented.
- R4: A primary write-back stores its data into pointer `wb_idx` at the next clock edge.
- R5: The secondary port selects pointer 2 when `sec_sel` is 0 and pointer 3 when it is 1, for both reading and write-back.
- R6: Primary and secondary write-backs to different pointers in the same cycle both commit. When both target the same pointer, the primary data wins.
- R7: A bus write to a pointer takes priority over any write-back to that pointer in the same cycle.
- R8: After a bus write to the pointer, offset or modifier of index k in cycle t, a primary request for index k in cycle t or t+1 raises `upd_hazard`. In cycle t+2 the flag is clear. Requests for other indices are not flagged.
- R9: `sec_hazard` is raised for a secondary request only by a bus write to the selected pointer itself, in the same cycle or the one before. Offset or modifier writes of that index do not raise it.
- R10: Write-backs never create a hazard, and neither hazard flag is raised without its request input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Host bus write strobe |
| bus_wr_cls | input | 2 | Write class: 0 pointer, 1 offset, 2 modifier, 3 none |
| bus_wr_idx | input | 2 | Write index |
| bus_wr_data | input | 16 | Write data |
| bus_rd_cls | input | 2 | Read class, same encoding |
| bus_rd_idx | input | 2 | Read index |
| bus_rd_data | output | 16 | Selected register contents |
| upd_req | input | 1 | Primary arithmetic wants to use a pointer this cycle |
| upd_idx | input | 2 | Primary pointer index |
| upd_ptr | output | 16 | Pointer at `upd_idx` |
| upd_ofs | output | 16 | Offset at `upd_idx` |
| upd_mod | output | 16 | Modifier at `upd_idx` |
| upd_hazard | output | 1 | Requested index still settling after a bus move |
| wb_en | input | 1 | Primary write-back strobe |
| wb_idx | input | 2 | Primary write-back pointer index |
| wb_data | input | 16 | Primary write-back value |
| sec_req | input | 1 | Secondary adder wants its pointer this cycle |
| sec_sel | input | 1 | Secondary read select: 0 pointer 2, 1 pointer 3 |
| sec_ptr | output | 16 | Selected secondary pointer |
| sec_hazard | output | 1 | Selected secondary pointer still settling |
| sec_wb_en | input | 1 | Secondary write-back strobe |
| sec_wb_sel | input | 1 | Secondary write-back target: 0 pointer 2, 1 pointer 3 |
| sec_wb_data | input | 16 | Secondary write-back value |

## Verification
The bench probes the hazard window at its edges: it requests an index in the cycle of its bus move, in the next cycle and in the cycle after. A window that is one step short misses the next-cycle flag, and one that is a step long flags a usable register. It writes an offset and a modifier of the secondary pointer's index to catch a secondary flag that is wrongly tied to the whole index. It drives the bus and both write-backs into one pointer in the same cycle. A wrong priority order then leaves arithmetic data where the host value or the primary value belongs. It also checks that a class 3 write leaves every bank intact and that modifiers leave reset as all ones.

// File: rtl/ptr_file_pkg.sv
package ptr_file_pkg;

    typedef enum logic [1:0] {
        CLS_PTR  = 2'd0,
        CLS_OFS  = 2'd1,
        CLS_MOD  = 2'd2,
        CLS_NONE = 2'd3
    } reg_cls_e;

    localparam int NUM_CLS = 3;

    // Reset value of one bank: modifiers come up as all ones.
    function automatic logic bank_resets_high(input int cls);
        return cls == int'(CLS_MOD);
    endfunction

    // Counter width needed to hold a settle count of lat-1.
    function automatic int settle_width(input int lat);
        return (lat > 2) ? $clog2(lat) : 1;
    endfunction

endpackage

// File: rtl/pf_reg_array.sv
module pf_reg_array #(
    parameter int          NREG    = 4,
    parameter int          DW      = 16,
    parameter logic [DW-1:0] RST_VAL = '0,
    localparam int         IW      = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_we,
    input  logic [IW-1:0]            bus_idx,
    input  logic [DW-1:0]            bus_data,
    input  logic                     a_we,
    input  logic [IW-1:0]            a_idx,
    input  logic [DW-1:0]            a_data,
    input  logic                     b_we,
    input  logic [IW-1:0]            b_idx,
    input  logic [DW-1:0]            b_data,
    output logic [NREG-1:0][DW-1:0]  q
);

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        // Priority per entry: host bus, then primary, then secondary.
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= RST_VAL;
            end else if (bus_we && bus_idx == IW'(i)) begin
                q[i] <= bus_data;
            end else if (a_we && a_idx == IW'(i)) begin
                q[i] <= a_data;
            end else if (b_we && b_idx == IW'(i)) begin
                q[i] <= b_data;
            end
        end
    end

endmodule

// File: rtl/pf_settle_track.sv
module pf_settle_track
    import ptr_file_pkg::*;
#(
    parameter int NREG = 4,
    parameter int LAT  = 2,
    localparam int IW  = $clog2(NREG),
    localparam int CW  = settle_width(LAT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic [IW-1:0]   set_idx,
    output logic [NREG-1:0] pend
);

    localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

    for (genvar i = 0; i < NREG; i++) begin : g_cnt
        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (set_en && set_idx == IW'(i)) begin
                cnt_q <= LOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign pend[i] = (cnt_q != '0);
    end

endmodule

// File: rtl/dsp_ptr_file.sv
module dsp_ptr_file
    import ptr_file_pkg::*;
#(
    parameter int NREG     = 4,
    parameter int DW       = 16,
    parameter int MOVE_LAT = 2,
    parameter int SEC_BASE = 2,
    localparam int IW      = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr_en,
    input  logic [1:0]     bus_wr_cls,
    input  logic [IW-1:0]  bus_wr_idx,
    input  logic [DW-1:0]  bus_wr_data,
    input  logic [1:0]     bus_rd_cls,
    input  logic [IW-1:0]  bus_rd_idx,
    output logic [DW-1:0]  bus_rd_data,
    input  logic           upd_req,
    input  logic [IW-1:0]  upd_idx,
    output logic [DW-1:0]  upd_ptr,
    output logic [DW-1:0]  upd_ofs,
    output logic [DW-1:0]  upd_mod,
    output logic           upd_hazard,
    input  logic           wb_en,
    input  logic [IW-1:0]  wb_idx,
    input  logic [DW-1:0]  wb_data,
    input  logic           sec_req,
    input  logic           sec_sel,
    output logic [DW-1:0]  sec_ptr,
    output logic           sec_hazard,
    input  logic           sec_wb_en,
    input  logic           sec_wb_sel,
    input  logic [DW-1:0]  sec_wb_data
);

    logic [NUM_CLS-1:0][NREG-1:0][DW-1:0] bank_q;
    logic [NUM_CLS-1:0][NREG-1:0]         pend;
    logic [NUM_CLS-1:0]                   cls_we;
    logic [IW-1:0]                        sec_rd_idx;
    logic [IW-1:0]                        sec_wr_idx;
    logic                                 bus_hits_any;

    assign sec_rd_idx = IW'(SEC_BASE) + IW'(sec_sel);
    assign sec_wr_idx = IW'(SEC_BASE) + IW'(sec_wb_sel);

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        localparam logic [DW-1:0] RV = bank_resets_high(c) ? '1 : '0;

        assign cls_we[c] = bus_wr_en && (bus_wr_cls == 2'(c));

        if (c == int'(CLS_PTR)) begin : g_ptr
            pf_reg_array #(.NREG(NREG), .DW(DW), .RST_VAL(RV)) u_bank (
                .clk(clk), .rst(rst),
                .bus_we(cls_we[c]), .bus_idx(bus_wr_idx), .bus_data(bus_wr_data),
                .a_we(wb_en), .a_idx(wb_idx), .a_data(wb_data),
                .b_we(sec_wb_en), .b_idx(sec_wr_idx), .b_data(sec_wb_data),
                .q(bank_q[c])
            );
        end else begin : g_aux
            pf_reg_array #(.NREG(NREG), .DW(DW), .RST_VAL(RV)) u_bank (
                .clk(clk), .rst(rst),
                .bus_we(cls_we[c]), .bus_idx(bus_wr_idx), .bus_data(bus_wr_data),
                .a_we(1'b0), .a_idx('0), .a_data('0),
                .b_we(1'b0), .b_idx('0), .b_data('0),
                .q(bank_q[c])
            );
        end

        pf_settle_track #(.NREG(NREG), .LAT(MOVE_LAT)) u_settle (
            .clk(clk), .rst(rst),
            .set_en(cls_we[c]), .set_idx(bus_wr_idx),
            .pend(pend[c])
        );
    end

    always_comb begin
        unique case (reg_cls_e'(bus_rd_cls))
            CLS_PTR: bus_rd_data = bank_q[CLS_PTR][bus_rd_idx];
            CLS_OFS: bus_rd_data = bank_q[CLS_OFS][bus_rd_idx];
            CLS_MOD: bus_rd_data = bank_q[CLS_MOD][bus_rd_idx];
            default: bus_rd_data = '0;
        endcase
    end

    assign upd_ptr = bank_q[CLS_PTR][upd_idx];
    assign upd_ofs = bank_q[CLS_OFS][upd_idx];
    assign upd_mod = bank_q[CLS_MOD][upd_idx];
    assign sec_ptr = bank_q[CLS_PTR][sec_rd_idx];

    // A move in the current cycle also counts as not yet usable.
    assign bus_hits_any = (cls_we != '0) && (bus_wr_idx == upd_idx);

    assign upd_hazard = upd_req && (bus_hits_any ||
                                    pend[CLS_PTR][upd_idx] ||
                                    pend[CLS_OFS][upd_idx] ||
                                    pend[CLS_MOD][upd_idx]);

    assign sec_hazard = sec_req && (pend[CLS_PTR][sec_rd_idx] ||
                                    (cls_we[CLS_PTR] && bus_wr_idx == sec_rd_idx));

endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
    parameter int NREG     = 4,
    parameter int DW       = 16,
    parameter int SEC_BASE = 2,
    localparam int IW      = $clog2(NREG)
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           bus_wr_en,
    input logic [1:0]                     bus_wr_cls,
    input logic [IW-1:0]                  bus_wr_idx,
    input logic [DW-1:0]                  bus_wr_data,
    input logic                           wb_en,
    input logic [IW-1:0]                  wb_idx,
    input logic [DW-1:0]                  wb_data,
    input logic                           sec_wb_en,
    input logic                           sec_wb_sel,
    input logic [DW-1:0]                  sec_wb_data,
    input logic                           upd_req,
    input logic [IW-1:0]                  upd_idx,
    input logic                           upd_hazard,
    input logic                           sec_req,
    input logic                           sec_hazard,
    input logic [2:0][NREG-1:0][DW-1:0]   bank_q
);

    logic [IW-1:0] chk_sec_idx;
    logic          bus_ptr_wr;
    assign chk_sec_idx = IW'(SEC_BASE) + IW'(sec_wb_sel);
    assign bus_ptr_wr  = bus_wr_en && bus_wr_cls == 2'd0;

    p_bus_beats_wb_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_ptr_wr && wb_en && wb_idx == bus_wr_idx)
        |=> bank_q[0][$past(bus_wr_idx)] == $past(bus_wr_data));

    p_wb_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (wb_en && !(bus_ptr_wr && bus_wr_idx == wb_idx))
        |=> bank_q[0][$past(wb_idx)] == $past(wb_data));

    p_sec_lands_r6: assert property (@(posedge clk) disable iff (rst)
        (sec_wb_en && !(wb_en && wb_idx == chk_sec_idx) &&
         !(bus_ptr_wr && bus_wr_idx == chk_sec_idx))
        |=> bank_q[0][$past(chk_sec_idx)] == $past(sec_wb_data));

    p_aux_banks_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_en |=> ($stable(bank_q[1]) && $stable(bank_q[2])));

    p_haz_after_move_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_wr_en) && $past(bus_wr_cls) != 2'd3 &&
         upd_req && upd_idx == $past(bus_wr_idx))
        |-> upd_hazard);

    p_upd_haz_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
        !upd_req |-> !upd_hazard);

    p_sec_haz_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
        !sec_req |-> !sec_hazard);

endmodule

bind dsp_ptr_file pf_checker #(.NREG(NREG), .DW(DW), .SEC_BASE(SEC_BASE)) u_pf_chk (.*);

// File: tb/test_dsp_ptr_file.sv
`timescale 1ns/1ps
module test_dsp_ptr_file;

    localparam int SEL_RD = 0, SEL_PTR = 1, SEL_OFS = 2, SEL_MOD = 3,
                   SEL_UHZ = 4, SEL_SPTR = 5, SEL_SHZ = 6;

    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst;
    logic bus_wr_en; logic [1:0] bus_wr_cls; logic [1:0] bus_wr_idx; logic [15:0] bus_wr_data;
    logic [1:0] bus_rd_cls; logic [1:0] bus_rd_idx; logic [15:0] bus_rd_data;
    logic upd_req; logic [1:0] upd_idx; logic [15:0] upd_ptr, upd_ofs, upd_mod; logic upd_hazard;
    logic wb_en; logic [1:0] wb_idx; logic [15:0] wb_data;
    logic sec_req, sec_sel; logic [15:0] sec_ptr; logic sec_hazard;
    logic sec_wb_en, sec_wb_sel; logic [15:0] sec_wb_data;

    item_t       sb_q[$];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 0;
    logic [15:0] mdl [3][4];

    always #2 clk = ~clk;

    dsp_ptr_file i_dsp_ptr_file (.*);

    task automatic idle();
        bus_wr_en = 0; bus_wr_cls = 0; bus_wr_idx = 0; bus_wr_data = 0;
        bus_rd_cls = 0; bus_rd_idx = 0;
        upd_req = 0; upd_idx = 0;
        wb_en = 0; wb_idx = 0; wb_data = 0;
        sec_req = 0; sec_sel = 0;
        sec_wb_en = 0; sec_wb_sel = 0; sec_wb_data = 0;
    endtask

    task automatic expect_out(input int sel, input logic [15:0] v, input string tag);
        item_t it;
        it.sel = sel; it.exp = v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic bus_write(input int c, input int k, input logic [15:0] d);
        bus_wr_en = 1; bus_wr_cls = 2'(c); bus_wr_idx = 2'(k); bus_wr_data = d;
        if (c < 3) mdl[c][k] = d;
    endtask

    function automatic logic [15:0] observe(input int sel);
        case (sel)
            SEL_RD:   return bus_rd_data;
            SEL_PTR:  return upd_ptr;
            SEL_OFS:  return upd_ofs;
            SEL_MOD:  return upd_mod;
            SEL_UHZ:  return {15'd0, upd_hazard};
            SEL_SPTR: return sec_ptr;
            default:  return {15'd0, sec_hazard};
        endcase
    endfunction

    // Monitor: compares queued expectations once outputs have settled.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] got;
                it  = sb_q.pop_front();
                got = observe(it.sel);
                n_vec++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, got, it.exp);
                end
            end
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset contents and no hazard
        for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); idle();
                bus_rd_cls = 2'(c); bus_rd_idx = 2'(k);
                mdl[c][k] = (c == 2) ? 16'hFFFF : 16'h0000;
                upd_req = 1; upd_idx = 2'(k);
                expect_out(SEL_RD, mdl[c][k], "R1");
                expect_out(SEL_UHZ, 16'd0, "R1");
            end
        end

        // R2: fill all banks with distinct values
        for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); idle();
                bus_write(c, k, 16'h1000 * 16'(c + 1) + 16'h0111 * 16'(k) + 16'h0005);
            end
        end
        @(negedge clk); idle();
        bus_write(3, 1, 16'hDEAD);           // R2: class 3 write goes nowhere
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); idle();
                bus_rd_cls = 2'(c); bus_rd_idx = 2'(k);
                expect_out(SEL_RD, (c < 3) ? mdl[c][k] : 16'h0000, "R2");
            end
        end

        // R3: aligned pointer/offset/modifier
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); idle();
            upd_idx = 2'(k);
            expect_out(SEL_PTR, mdl[0][k], "R3");
            expect_out(SEL_OFS, mdl[1][k], "R3");
            expect_out(SEL_MOD, mdl[2][k], "R3");
        end

        // R8: modifier move on index 1, probe cycles t, t+1, t+2
        @(negedge clk); idle();
        upd_req = 1; upd_idx = 1;
        expect_out(SEL_UHZ, 16'd1, "R8");
        bus_write(2, 1, 16'h00F0);
        @(negedge clk); idle();
        upd_req = 1; upd_idx = 1;
        expect_out(SEL_UHZ, 16'd1, "R8");
        expect_out(SEL_MOD, 16'h00F0, "R8");
        @(negedge clk); idle();
        upd_req = 1; upd_idx = 1;
        expect_out(SEL_UHZ, 16'd0, "R8");
        // R8: offset move on index 2 does not flag index 3
        @(negedge clk); idle();
        bus_write(1, 2, 16'h0042);
        upd_req = 1; upd_idx = 3;
        expect_out(SEL_UHZ, 16'd0, "R8");
        @(negedge clk); idle();
        upd_req = 1; upd_idx = 3;
        expect_out(SEL_UHZ, 16'd0, "R8");
        @(negedge clk); idle();
        upd_req = 1; upd_idx = 2;
        expect_out(SEL_UHZ, 16'd0, "R8");

        // R10: pending register without request; write-back arms nothing
        @(negedge clk); idle();
        bus_write(0, 0, 16'h0BAD);
        @(negedge clk); idle();
        upd_idx = 0;
        expect_out(SEL_UHZ, 16'd0, "R10");
        wb_en = 1; wb_idx = 1; wb_data = 16'h7A7A; mdl[0][1] = 16'h7A7A;
        @(negedge clk); idle();
        upd_req = 1; upd_idx = 1;
        expect_out(SEL_UHZ, 16'd0, "R10");
        expect_out(SEL_PTR, 16'h7A7A, "R4");

        // R5: secondary selection
        @(negedge clk); idle();
        sec_sel = 0;
        expect_out(SEL_SPTR, mdl[0][2], "R5");
        @(negedge clk); idle();
        sec_sel = 1;
        expect_out(SEL_SPTR, mdl[0][3], "R5");

        // R6: different targets both commit
        @(negedge clk); idle();
        wb_en = 1; wb_idx = 1; wb_data = 16'hA111; mdl[0][1] = 16'hA111;
        sec_wb_en = 1; sec_wb_sel = 1; sec_wb_data = 16'hB333; mdl[0][3] = 16'hB333;
        @(negedge clk); idle();
        upd_idx = 1; sec_sel = 1;
        expect_out(SEL_PTR, 16'hA111, "R6");
        expect_out(SEL_SPTR, 16'hB333, "R6");
        // R6: same target, primary wins
        wb_en = 1; wb_idx = 2; wb_data = 16'hC222; mdl[0][2] = 16'hC222;
        sec_wb_en = 1; sec_wb_sel = 0; sec_wb_data = 16'hD222;
        @(negedge clk); idle();
        sec_sel = 0;
        expect_out(SEL_SPTR, 16'hC222, "R6");

        // R7: bus beats both write-backs on pointer 3
        bus_write(0, 3, 16'hE333);
        wb_en = 1; wb_idx = 3; wb_data = 16'hF333;
        sec_wb_en = 1; sec_wb_sel = 1; sec_wb_data = 16'h9333;
        @(negedge clk); idle();
        upd_idx = 3;
        expect_out(SEL_PTR, 16'hE333, "R7");

        // R9: offset move on index 3 leaves secondary clear
        @(negedge clk); idle();
        bus_write(1, 3, 16'h0077);
        sec_req = 1; sec_sel = 1;
        expect_out(SEL_SHZ, 16'd0, "R9");
        @(negedge clk); idle();
        sec_req = 1; sec_sel = 1;
        expect_out(SEL_SHZ, 16'd0, "R9");
        // R9: pointer move on pointer 3 flags for two cycles
        @(negedge clk); idle();
        bus_write(0, 3, 16'h1234);
        sec_req = 1; sec_sel = 1;
        expect_out(SEL_SHZ, 16'd1, "R9");
        @(negedge clk); idle();
        sec_req = 1; sec_sel = 1;
        expect_out(SEL_SHZ, 16'd1, "R9");
        expect_out(SEL_SPTR, 16'h1234, "R9");
        @(negedge clk); idle();
        sec_req = 1; sec_sel = 1;
        expect_out(SEL_SHZ, 16'd0, "R9");

        @(negedge clk); idle();
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule